// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns one parallel character at a time into an asynchronous serial frame on a single line. A packed 8-bit line control value selects how many data bits are sent (5 to 8), how long the stop period is (1, 1.5 or 2 bit times), whether a parity bit is added and how it is formed, and whether the line is forced to the space level as a break.

Characters arrive over a valid/ready handshake. The block accepts a character only when it is idle. At that moment it captures the character and every control field except break. A tick enable running at sixteen times the baud rate advances the frame. Break is read live from the control input and overrides the line at any moment without changing frame timing. A busy flag covers the whole frame, from the accepting edge to the end of the stop period.

Top module: `sertx_core`

## Requirements
- R1: After reset the line is high (mark), busy is low and ready is high; while no frame is in progress and break is clear the line stays high.
- R2: A frame begins with one start bit at 0, followed by the data bits least significant first; each start, data and parity bit lasts 16 ticks, counted from the edge that accepts the character.
- R3: Control bits [1:0] set the data length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8; data bits above the length are not sent.
- R4: Control bit 2 at 0 gives a 16-tick stop period. At 1 it gives 24 ticks (1.5 bits) for 5-bit characters and 32 ticks (2 bits) for 6, 7 or 8 bits. The line is high throughout the stop period and busy falls when it ends.
- R5: Control bit 3 at 1 inserts one parity bit between the last data bit and the stop period; at 0 no parity bit is sent.
- R6: With parity on and bit 5 at 0, bit 4 at 0 makes the count of ones across the sent data bits and the parity bit odd, and bit 4 at 1 makes it even.
- R7: With parity on and bit 5 at 1, the parity bit is constant: 0 when bit 4 is 1 and 1 when bit 4 is 0.
- R8: While control bit 6 is 1 the line is 0, whether idle or mid-frame. Frame timing and busy are unaffected, and the line returns to normal output as soon as the bit clears.
- R9: Control bits [5:0] are sampled on the accepting edge; changes to them during a frame do not alter that frame.
- R10: Ready is low for the whole frame, and valid asserted during a frame starts no new character.
- R11: While the tick enable is low the frame does not advance: the line level and busy hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_data | input | 8 | Character to send |
| in_ctrl | input | 8 | Line control value (length, stop, parity, break) |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Block can accept a character |
| tick_en | input | 1 | Sixteen-times-baud advance enable |
| tx_line | output | 1 | Serial output, idles high |
| busy | output | 1 | Frame in progress |

## Verification
A wrong bit index, shift register or tick count shows on the line within one bit time, as a level that differs from the computed waveform somewhere in the frame. A wrong stop limit or state step shows at the end of the frame, as busy falling at a tick other than the one expected. A stored control field that drifts mid-frame shows as a different length, parity level or stop period in that same frame. The bench sweeps every combination of the six frame-shaping control bits over several data patterns and compares the line and busy on every cycle of every frame, so any such fault is seen in the first frame that exercises it.

// File: rtl/sertx_pkg.sv
`timescale 1ns/1ps
package sertx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP
   } tx_state_e;

   typedef struct packed {
      logic [1:0] len_sel;
      logic       stop_ext;
      logic       par_en;
      logic       par_even;
      logic       par_stick;
   } line_cfg_t;

   function automatic line_cfg_t unpack_ctrl(input logic [7:0] c);
      line_cfg_t r;
      r.len_sel   = c[1:0];
      r.stop_ext  = c[2];
      r.par_en    = c[3];
      r.par_even  = c[4];
      r.par_stick = c[5];
      return r;
   endfunction

   function automatic logic [3:0] char_bits(input logic [1:0] sel);
      return 4'd5 + {2'b00, sel};
   endfunction

endpackage

// File: rtl/sertx_cfg_reg.sv
`timescale 1ns/1ps
module sertx_cfg_reg
   import sertx_pkg::*;
#(
   parameter int TPB = 16,
   localparam int CW = $clog2(2 * TPB)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [7:0]    ctrl,
   output logic [3:0]    nbits,
   output logic          par_en,
   output logic [CW-1:0] stop_lim
);

   localparam logic [CW-1:0] LIM_ONE  = CW'(TPB - 1);
   localparam logic [CW-1:0] LIM_HALF = CW'(TPB + TPB / 2 - 1);
   localparam logic [CW-1:0] LIM_TWO  = CW'(2 * TPB - 1);

   line_cfg_t cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (load) begin
         cfg_q <= unpack_ctrl(ctrl);
      end
   end

   always_comb begin
      nbits  = char_bits(cfg_q.len_sel);
      par_en = cfg_q.par_en;
      if (!cfg_q.stop_ext) begin
         stop_lim = LIM_ONE;
      end else if (cfg_q.len_sel == 2'b00) begin
         stop_lim = LIM_HALF;
      end else begin
         stop_lim = LIM_TWO;
      end
   end

endmodule

// File: rtl/sertx_parity.sv
`timescale 1ns/1ps
module sertx_parity
   import sertx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] data,
   input  logic [7:0]        ctrl,
   output logic              par_bit
);

   line_cfg_t         cfg;
   logic [3:0]        nb;
   logic [DATA_W-1:0] mask;
   logic              ones_odd;

   assign cfg = unpack_ctrl(ctrl);
   assign nb  = char_bits(cfg.len_sel);

   for (genvar i = 0; i < DATA_W; i++) begin : g_mask
      assign mask[i] = (4'(i) < nb);
   end

   assign ones_odd = ^(data & mask);

   always_comb begin
      if (cfg.par_stick) begin
         par_bit = ~cfg.par_even;
      end else if (cfg.par_even) begin
         par_bit = ones_odd;
      end else begin
         par_bit = ~ones_odd;
      end
   end

endmodule

// File: rtl/sertx_bitclk.sv
`timescale 1ns/1ps
module sertx_bitclk #(
   parameter int TPB = 16,
   localparam int CW = $clog2(2 * TPB)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          run,
   input  logic [CW-1:0] limit,
   output logic          done
);

   logic [CW-1:0] cnt;

   assign done = run && !clr && (cnt == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr || done) begin
         cnt <= '0;
      end else if (run) begin
         cnt <= cnt + 1'b1;
      end
   end

   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt <= limit)); // R4

endmodule

// File: rtl/sertx_seq.sv
`timescale 1ns/1ps
module sertx_seq
   import sertx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int TPB    = 16,
   localparam int CW    = $clog2(2 * TPB),
   localparam int IW    = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              bit_done,
   input  logic [DATA_W-1:0] data,
   input  logic              par_in,
   input  logic [3:0]        nbits,
   input  logic              par_en,
   input  logic [CW-1:0]     stop_lim,
   output logic [CW-1:0]     limit,
   output logic              line_raw,
   output logic              busy
);

   localparam logic [CW-1:0] BIT_LIM = CW'(TPB - 1);

   tx_state_e         st;
   logic [DATA_W-1:0] shreg;
   logic [IW-1:0]     idx;
   logic              par_q;
   logic              last_data;

   assign last_data = ({1'b0, idx} == 4'(nbits - 4'd1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         shreg <= '0;
         idx   <= '0;
         par_q <= 1'b0;
      end else if (accept) begin
         st    <= ST_START;
         shreg <= data;
         idx   <= '0;
         par_q <= par_in;
      end else if (bit_done) begin
         unique case (st)
            ST_START: st <= ST_DATA;
            ST_DATA: begin
               shreg <= shreg >> 1;
               if (last_data) begin
                  st <= par_en ? ST_PAR : ST_STOP;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            ST_PAR:  st <= ST_STOP;
            ST_STOP: st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      unique case (st)
         ST_START: line_raw = 1'b0;
         ST_DATA:  line_raw = shreg[0];
         ST_PAR:   line_raw = par_q;
         default:  line_raw = 1'b1;
      endcase
   end

   assign limit = (st == ST_STOP) ? stop_lim : BIT_LIM;
   assign busy  = (st != ST_IDLE);

   AST_STOP_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_STOP) |-> line_raw); // R4

   AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (st != ST_IDLE) && (st != ST_START) |=> (st != ST_START)); // R10

endmodule

// File: rtl/sertx_core.sv
`timescale 1ns/1ps
module sertx_core #(
   parameter int DATA_W  = 8,
   parameter int TPB     = 16,
   parameter int BRK_BIT = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] in_data,
   input  logic [7:0]        in_ctrl,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic              tick_en,
   output logic              tx_line,
   output logic              busy
);

   localparam int CW = $clog2(2 * TPB);

   if (DATA_W != 8) begin : g_bad_width
      $error("sertx_core: DATA_W must be 8");
   end
   if ((TPB < 2) || (TPB % 2 != 0)) begin : g_bad_tpb
      $error("sertx_core: TPB must be even and at least 2");
   end
   if ((BRK_BIT < 6) || (BRK_BIT > 7)) begin : g_bad_brk
      $error("sertx_core: BRK_BIT must lie outside the frame fields");
   end

   logic          accept;
   logic          bit_done;
   logic          par_bit;
   logic          par_en;
   logic [3:0]    nbits;
   logic [CW-1:0] stop_lim;
   logic [CW-1:0] limit;
   logic          line_raw;
   logic          brk;

   assign in_ready = !busy;
   assign accept   = in_valid && in_ready;
   assign brk      = in_ctrl[BRK_BIT];

   sertx_cfg_reg #(.TPB(TPB)) cfg_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .ctrl     (in_ctrl),
      .nbits    (nbits),
      .par_en   (par_en),
      .stop_lim (stop_lim)
   );

   sertx_parity #(.DATA_W(DATA_W)) par_i (
      .data    (in_data),
      .ctrl    (in_ctrl),
      .par_bit (par_bit)
   );

   sertx_bitclk #(.TPB(TPB)) clk_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (accept),
      .run   (tick_en && busy),
      .limit (limit),
      .done  (bit_done)
   );

   sertx_seq #(.DATA_W(DATA_W), .TPB(TPB)) seq_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (accept),
      .bit_done (bit_done),
      .data     (in_data),
      .par_in   (par_bit),
      .nbits    (nbits),
      .par_en   (par_en),
      .stop_lim (stop_lim),
      .limit    (limit),
      .line_raw (line_raw),
      .busy     (busy)
   );

   assign tx_line = brk ? 1'b0 : line_raw;

   AST_START_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (busy && !line_raw)); // R2

   AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !brk) |-> tx_line); // R1

   AST_FROZEN_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tick_en) |=> (busy && $stable(line_raw))); // R11

endmodule

// File: tb/sertx_core_tb_top.sv
`timescale 1ns/1ps
module sertx_core_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic [7:0] in_ctrl = 8'h00;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic       tick_en = 1'b0;
   logic       tx_line;
   logic       busy;

   int  n_vec = 0;
   int  n_bad = 0;
   bit  finished = 1'b0;

   always #2.5 clk = ~clk;

   sertx_core dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_data  (in_data),
      .in_ctrl  (in_ctrl),
      .in_valid (in_valid),
      .in_ready (in_ready),
      .tick_en  (tick_en),
      .tx_line  (tx_line),
      .busy     (busy)
   );

   function automatic int nb_of(input logic [7:0] c);
      return 5 + int'(c[1:0]);
   endfunction

   function automatic int body_of(input logic [7:0] c);
      return 16 * (1 + nb_of(c) + int'(c[3]));
   endfunction

   function automatic int total_of(input logic [7:0] c);
      int s;
      if (!c[2]) s = 16;
      else if (c[1:0] == 2'b00) s = 24;
      else s = 32;
      return body_of(c) + s;
   endfunction

   function automatic logic par_of(input logic [7:0] d, input logic [7:0] c);
      int ones = 0;
      for (int i = 0; i < nb_of(c); i++) ones += int'(d[i]);
      if (c[5]) return ~c[4];
      if (c[4]) return logic'(ones % 2);
      return logic'((ones + 1) % 2);
   endfunction

   function automatic logic line_of(input logic [7:0] d, input logic [7:0] c, input int t);
      int seg = t / 16;
      if (seg == 0) return 1'b0;
      if (seg <= nb_of(c)) return d[seg - 1];
      if (t < body_of(c)) return par_of(d, c);
      return 1'b1;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // One frame; t counts ticked edges after the accepting edge.
   task automatic run_frame(input logic [7:0] d, input logic [7:0] c,
                            input logic [7:0] c_late, input int frz_at,
                            input int frz_len, input int brk_from, input int brk_to,
                            input bit hold_valid, input string req);
      int   t = 0;
      int   frz_left = frz_len;
      int   total = total_of(c);
      bit   bad = 1'b0;
      int   bad_t = 0;
      int   act = 0;
      int   exp = 0;
      logic brk_now;
      logic el;
      @(negedge clk);
      in_data  = d;
      in_ctrl  = {2'b00, c[5:0]};
      tick_en  = 1'b1;
      #1;
      check(in_ready == 1'b1, req, "ready before accept", int'(in_ready), 1);
      in_valid = 1'b1;
      @(posedge clk);
      forever begin
         @(negedge clk);
         brk_now  = (t >= brk_from) && (t < brk_to);
         in_valid = hold_valid && (t < total - 4);
         in_data  = hold_valid ? 8'h00 : d;
         in_ctrl  = {1'b0, brk_now, c_late[5:0]};
         #1;
         if (t == total) begin
            if (!bad && (busy !== 1'b0 || tx_line !== !brk_now)) begin
               bad = 1'b1; bad_t = t; act = int'({busy, tx_line}); exp = int'(!brk_now);
            end
            break;
         end
         el = brk_now ? 1'b0 : line_of(d, c, t);
         if (!bad && (tx_line !== el || busy !== 1'b1 || in_ready !== 1'b0)) begin
            bad = 1'b1; bad_t = t;
            act = int'({busy, in_ready, tx_line}); exp = int'({2'b10, el});
         end
         if (t == frz_at && frz_left > 0) begin
            tick_en = 1'b0;
            frz_left--;
         end else begin
            tick_en = 1'b1;
         end
         @(posedge clk);
         if (tick_en) t++;
      end
      in_valid = 1'b0;
      in_ctrl  = {2'b00, c[5:0]};
      check(!bad, req, $sformatf("frame d=%02h c=%02h tick=%0d {busy,ready,line}", d, c, bad_t),
            act, exp);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] dv [4];
      dv[0] = 8'hA5; dv[1] = 8'h3C; dv[2] = 8'hFF; dv[3] = 8'h00;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      // R1: reset state
      check(tx_line === 1'b1, "R1", "line after reset", int'(tx_line), 1);
      check(busy === 1'b0, "R1", "busy after reset", int'(busy), 0);
      check(in_ready === 1'b1, "R1", "ready after reset", int'(in_ready), 1);

      // R8: break while idle, then release
      in_ctrl = 8'h40;
      #1;
      check(tx_line === 1'b0, "R8", "line under idle break", int'(tx_line), 0);
      check(busy === 1'b0, "R8", "busy under idle break", int'(busy), 0);
      @(negedge clk);
      in_ctrl = 8'h00;
      #1;
      check(tx_line === 1'b1, "R8", "line after break release", int'(tx_line), 1);

      // R2 R3 R4 R5 R6 R7: all frame-shaping control values over data patterns
      for (int c = 0; c < 64; c++) begin
         for (int k = 0; k < 3; k++) begin
            logic [7:0] d = (k == 2) ? 8'(c * 37 + 11) : dv[(c + k) % 4];
            run_frame(d, 8'(c), 8'(c), -1, 0, -1, -1, 1'b0, "R2/R3/R4/R5/R6/R7");
         end
      end

      // R8: break inside a frame, timing unchanged
      run_frame(8'hC3, 8'h1B, 8'h1B, -1, 0, 20, 70, 1'b0, "R8");
      run_frame(8'h55, 8'h04, 8'h04, -1, 0, 0, 90, 1'b0, "R8");

      // R9: control bits altered mid-frame
      run_frame(8'h96, 8'h0F, 8'h30, -1, 0, -1, -1, 1'b0, "R9");
      run_frame(8'h6E, 8'h00, 8'h3F, -1, 0, -1, -1, 1'b0, "R9");

      // R10: valid held during a frame
      run_frame(8'hE7, 8'h0B, 8'h0B, -1, 0, -1, -1, 1'b1, "R10");
      repeat (6) begin
         @(negedge clk);
         #1;
         check(busy === 1'b0 && tx_line === 1'b1, "R10", "idle after ignored valid",
               int'({busy, tx_line}), 1);
      end

      // R11: tick enable low mid-frame
      run_frame(8'h5A, 8'h03, 8'h03, 20, 40, -1, -1, 1'b0, "R11");
      run_frame(8'h81, 8'h1F, 8'h1F, 130, 25, -1, -1, 1'b0, "R11");

      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule